// File: doc/BRIEF.md
# Dual Converter Result Packer

This block sits between two analog-to-digital converters, one acting as master and one as slave, and a DMA engine. Each converter signals an end-of-conversion pulse along with its result. The block stores every result in a data register for that side and latches a pending flag that stays set until the DMA has taken the result. A 2-bit mode input selects how the results are offered to the DMA.

In separate mode, each side has its own request/acknowledge pair. In the two combined modes, the block waits until both sides hold an unread result. It then offers one 32-bit word, with the slave result in the upper half and the master result in the lower half, on a single request. One of the combined modes passes full-width results. The other keeps only the low 8 bits of each side and zero-extends them.

Every request output acts as a stream valid, and its acknowledge acts as the matching ready. A transfer happens on a rising clock edge where both are high. A raised request stays high, with its data held steady, for as long as the acknowledge stays low. The request drops in the cycle after the transfer. An acknowledge given while the request is low has no effect.

Top module: `dual_result_packer`

## Requirements
- R1: An end-of-conversion pulse on a side loads that side's result into its data register and sets its pending flag, both visible in the next cycle.
- R2: With mode_sel = 2'b00, each side drives its own request while its pending flag is set. A transfer on that side's acknowledge clears only that side's flag. An acknowledge while the side's request is low changes nothing.
- R3: With mode_sel = 2'b10 or 2'b11, comb_req is high only while both pending flags are set. The two events may come in either order or in the same cycle. Both per-side requests stay low in these modes.
- R4: With mode_sel = 2'b10, comb_word[31:16] is the slave data register and comb_word[15:0] is the master data register.
- R5: With mode_sel = 2'b11, comb_word is {8'h00, slave[7:0], 8'h00, master[7:0]}.
- R6: comb_req stays high while comb_ack is low. A transfer clears both pending flags, and comb_req is low in the next cycle.
- R7: An end-of-conversion pulse on a side whose pending flag is set, and is not being cleared at that edge, sets that side's sticky overrun flag. The new result replaces the old one. Only reset clears the overrun flag.
- R8: With mode_sel = 2'b01, no request is raised, although the flags and data registers still update. comb_word reads zero in modes 2'b00 and 2'b01.
- R9: After reset, all requests, pending flags, overrun flags and data registers are zero.
- R10: An end-of-conversion pulse at the same edge as a transfer that clears that side leaves the flag pending with the new result, and sets no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 00 separate, 01 requests off, 10 combined full width, 11 combined 8-bit |
| mst_eoc | input | 1 | Master end-of-conversion pulse |
| mst_data | input | 16 | Master result |
| slv_eoc | input | 1 | Slave end-of-conversion pulse |
| slv_data | input | 16 | Slave result |
| mst_ack | input | 1 | Ready for the master request |
| slv_ack | input | 1 | Ready for the slave request |
| comb_ack | input | 1 | Ready for the combined request |
| mst_req | output | 1 | Master request (valid), separate mode |
| slv_req | output | 1 | Slave request (valid), separate mode |
| comb_req | output | 1 | Combined request (valid) |
| comb_word | output | 32 | Packed common word |
| mst_dr | output | 16 | Master data register |
| slv_dr | output | 16 | Slave data register |
| mst_pend | output | 1 | Master unread-result flag |
| slv_pend | output | 1 | Slave unread-result flag |
| mst_ovr | output | 1 | Master overrun flag |
| slv_ovr | output | 1 | Slave overrun flag |

## Verification
Combined mode is driven with master-first, slave-first and same-cycle event arrivals. This separates a real wait for both sides from a request that fires on either single side. In separate mode, an acknowledge is sent to the idle side to show that the sides are independent. A long hold with the acknowledge low, followed by a transfer, tells a held request from one that is pulsed. Back-to-back events, and an event at the same edge as a transfer, tell an overrun apart from a clean refill. The data values are chosen so that nonzero upper bytes expose any mistake in the half-word order or in the 8-bit zero-extension.

// File: rtl/drp_pkg.sv
package drp_pkg;
  typedef enum logic [1:0] {
    MODE_SEPARATE = 2'b00,
    MODE_OFF      = 2'b01,
    MODE_WIDE     = 2'b10,
    MODE_NARROW   = 2'b11
  } pack_mode_e;

  localparam int SIDES    = 2;
  localparam int SIDE_MST = 0;
  localparam int SIDE_SLV = 1;
endpackage

// File: rtl/drp_side_slot.sv
module drp_side_slot #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoc_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             clr_i,
  output logic [RES_W-1:0] dr_o,
  output logic             pend_o,
  output logic             ovr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_o   <= '0;
      pend_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else if (eoc_i) begin
      dr_o   <= data_i;
      pend_o <= 1'b1;
      // unread result being replaced
      if (pend_o && !clr_i) ovr_o <= 1'b1;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/drp_req_ctrl.sv
module drp_req_ctrl
  import drp_pkg::*;
(
  input  logic [1:0]       mode_i,
  input  logic [SIDES-1:0] pend_i,
  input  logic [SIDES-1:0] side_ack_i,
  input  logic             comb_ack_i,
  output logic [SIDES-1:0] side_req_o,
  output logic             comb_req_o,
  output logic [SIDES-1:0] clr_o
);
  pack_mode_e mode;
  assign mode = pack_mode_e'(mode_i);

  always_comb begin
    side_req_o = '0;
    comb_req_o = 1'b0;
    clr_o      = '0;
    case (mode)
      MODE_SEPARATE: begin
        for (int i = 0; i < SIDES; i++) begin
          side_req_o[i] = pend_i[i];
          clr_o[i]      = pend_i[i] & side_ack_i[i];
        end
      end
      MODE_WIDE, MODE_NARROW: begin
        comb_req_o = &pend_i;
        clr_o      = {SIDES{comb_req_o & comb_ack_i}};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/drp_word_pack.sv
module drp_word_pack
  import drp_pkg::*;
#(
  parameter int RES_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic [1:0]               mode_i,
  input  logic [SIDES*RES_W-1:0]   dr_flat_i,
  output logic [SIDES*RES_W-1:0]   word_o
);
  localparam int PAD_W = RES_W - NARROW_W;

  // side 0 (master) fills the low half, side 1 (slave) the high half
  for (genvar g = 0; g < SIDES; g++) begin : g_half
    logic [RES_W-1:0] dr;
    assign dr = dr_flat_i[g*RES_W +: RES_W];
    always_comb begin
      case (pack_mode_e'(mode_i))
        MODE_WIDE:   word_o[g*RES_W +: RES_W] = dr;
        MODE_NARROW: word_o[g*RES_W +: RES_W] = {{PAD_W{1'b0}}, dr[NARROW_W-1:0]};
        default:     word_o[g*RES_W +: RES_W] = '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_result_packer.sv
module dual_result_packer
  import drp_pkg::*;
#(
  parameter int RES_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               mst_eoc,
  input  logic [RES_W-1:0]   mst_data,
  input  logic               slv_eoc,
  input  logic [RES_W-1:0]   slv_data,
  input  logic               mst_ack,
  input  logic               slv_ack,
  input  logic               comb_ack,
  output logic               mst_req,
  output logic               slv_req,
  output logic               comb_req,
  output logic [2*RES_W-1:0] comb_word,
  output logic [RES_W-1:0]   mst_dr,
  output logic [RES_W-1:0]   slv_dr,
  output logic               mst_pend,
  output logic               slv_pend,
  output logic               mst_ovr,
  output logic               slv_ovr
);
  localparam int FLAT_W = SIDES * RES_W;

  logic [SIDES-1:0] eoc, pend, ovr, clr, side_ack, side_req;
  logic [FLAT_W-1:0] data_flat, dr_flat;

  assign eoc       = {slv_eoc, mst_eoc};
  assign data_flat = {slv_data, mst_data};
  assign side_ack  = {slv_ack, mst_ack};

  for (genvar g = 0; g < SIDES; g++) begin : g_slot
    drp_side_slot #(.RES_W(RES_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .eoc_i  (eoc[g]),
      .data_i (data_flat[g*RES_W +: RES_W]),
      .clr_i  (clr[g]),
      .dr_o   (dr_flat[g*RES_W +: RES_W]),
      .pend_o (pend[g]),
      .ovr_o  (ovr[g])
    );
  end

  drp_req_ctrl u_ctrl (
    .mode_i     (mode_sel),
    .pend_i     (pend),
    .side_ack_i (side_ack),
    .comb_ack_i (comb_ack),
    .side_req_o (side_req),
    .comb_req_o (comb_req),
    .clr_o      (clr)
  );

  drp_word_pack #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_pack (
    .mode_i    (mode_sel),
    .dr_flat_i (dr_flat),
    .word_o    (comb_word)
  );

  assign mst_req  = side_req[SIDE_MST];
  assign slv_req  = side_req[SIDE_SLV];
  assign mst_dr   = dr_flat[SIDE_MST*RES_W +: RES_W];
  assign slv_dr   = dr_flat[SIDE_SLV*RES_W +: RES_W];
  assign mst_pend = pend[SIDE_MST];
  assign slv_pend = pend[SIDE_SLV];
  assign mst_ovr  = ovr[SIDE_MST];
  assign slv_ovr  = ovr[SIDE_SLV];
endmodule

// File: rtl/drp_checker.sv
module drp_checker #(
  parameter int RES_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode_sel,
  input logic               mst_eoc,
  input logic [RES_W-1:0]   mst_data,
  input logic               slv_eoc,
  input logic               mst_ack,
  input logic               comb_ack,
  input logic               mst_req,
  input logic               slv_req,
  input logic               comb_req,
  input logic [2*RES_W-1:0] comb_word,
  input logic [RES_W-1:0]   mst_dr,
  input logic [RES_W-1:0]   slv_dr,
  input logic               mst_pend,
  input logic               slv_pend,
  input logic               mst_ovr
);
  AST_EOC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    mst_eoc |=> (mst_pend && mst_dr == $past(mst_data))); // R1

  AST_COMB_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    comb_req |-> (mst_pend && slv_pend)); // R3

  AST_NO_SIDE_REQ_COMB: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel[1] |-> (!mst_req && !slv_req)); // R3

  AST_WIDE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |-> (comb_word == {slv_dr, mst_dr})); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_req && !comb_ack && $stable(mode_sel)) |=> comb_req); // R6

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_req && comb_ack && !mst_eoc && !slv_eoc) |=> !comb_req); // R6

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_pend && mst_eoc && !mst_ack && !comb_ack) |=> mst_ovr); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mst_ovr |=> mst_ovr); // R7

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |-> (!mst_req && !slv_req && !comb_req && comb_word == '0)); // R8
endmodule

bind dual_result_packer drp_checker #(.RES_W(RES_W)) u_drp_checker (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mst_eoc(mst_eoc),
  .mst_data(mst_data), .slv_eoc(slv_eoc), .mst_ack(mst_ack),
  .comb_ack(comb_ack), .mst_req(mst_req), .slv_req(slv_req),
  .comb_req(comb_req), .comb_word(comb_word), .mst_dr(mst_dr),
  .slv_dr(slv_dr), .mst_pend(mst_pend), .slv_pend(slv_pend),
  .mst_ovr(mst_ovr)
);

// File: tb/test_dual_result_packer.sv
`timescale 1ns/1ps
module test_dual_result_packer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic mst_eoc = 0, slv_eoc = 0, mst_ack = 0, slv_ack = 0, comb_ack = 0;
  logic [15:0] mst_data = '0, slv_data = '0;
  logic mst_req, slv_req, comb_req, mst_pend, slv_pend, mst_ovr, slv_ovr;
  logic [31:0] comb_word;
  logic [15:0] mst_dr, slv_dr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_result_packer i_dual_result_packer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .mst_eoc(mst_eoc), .mst_data(mst_data), .slv_eoc(slv_eoc), .slv_data(slv_data),
    .mst_ack(mst_ack), .slv_ack(slv_ack), .comb_ack(comb_ack),
    .mst_req(mst_req), .slv_req(slv_req), .comb_req(comb_req), .comb_word(comb_word),
    .mst_dr(mst_dr), .slv_dr(slv_dr), .mst_pend(mst_pend), .slv_pend(slv_pend),
    .mst_ovr(mst_ovr), .slv_ovr(slv_ovr)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] md);
    @(negedge clk);
    rst_n = 0; mst_eoc = 0; slv_eoc = 0; mst_ack = 0; slv_ack = 0; comb_ack = 0;
    mode_sel = md;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic eoc(input bit m, input bit s, input logic [15:0] md, input logic [15:0] sd);
    mst_eoc = m; slv_eoc = s; mst_data = md; slv_data = sd;
    @(negedge clk);
    mst_eoc = 0; slv_eoc = 0;
  endtask

  task automatic t_reset();
    do_reset(2'b10);
    chk({mst_req, slv_req, comb_req, mst_pend, slv_pend, mst_ovr, slv_ovr}, 0, "R9 flags after reset");
    chk({mst_dr, slv_dr}, 0, "R9 data regs after reset");
  endtask

  task automatic t_separate();
    do_reset(2'b00);
    eoc(1, 0, 16'h1234, 16'h0);
    chk(mst_dr, 16'h1234, "R1 master data reg");
    chk({mst_pend, mst_req, slv_req}, 3'b110, "R2 master only request");
    chk(comb_word, 0, "R8 word zero in separate mode");
    slv_ack = 1; @(negedge clk); slv_ack = 0;
    chk({mst_req, slv_req}, 2'b10, "R2 idle-side ack ignored");
    mst_ack = 1; @(negedge clk); mst_ack = 0;
    chk({mst_req, mst_pend}, 2'b00, "R2 master cleared by ack");
    eoc(0, 1, 16'h0, 16'hBEEF);
    chk({slv_req, slv_dr}, {1'b1, 16'hBEEF}, "R1 slave capture and request");
    slv_ack = 1; @(negedge clk); slv_ack = 0;
    chk(slv_req, 0, "R2 slave cleared by ack");
  endtask

  task automatic t_comb_orders();
    do_reset(2'b10);
    eoc(1, 0, 16'h0ABC, 16'h0);
    chk({comb_req, mst_req}, 2'b00, "R3 no request on master alone");
    eoc(0, 1, 16'h0, 16'h0DEF);
    chk(comb_req, 1, "R3 request after both (master first)");
    chk(comb_word, 32'h0DEF0ABC, "R4 wide packing order");
    comb_ack = 1; @(negedge clk); comb_ack = 0;
    chk({comb_req, mst_pend, slv_pend}, 0, "R6 ack clears both");
    eoc(0, 1, 16'h0, 16'hF00D);
    chk(comb_req, 0, "R3 no request on slave alone");
    eoc(1, 0, 16'hCAFE, 16'h0);
    chk(comb_word, 32'hF00DCAFE, "R4 slave-first packing");
    comb_ack = 1; @(negedge clk); comb_ack = 0;
    eoc(1, 1, 16'h1357, 16'h2468);
    chk({comb_req, comb_word}, {1'b1, 32'h24681357}, "R3 same-cycle pair");
  endtask

  task automatic t_hold();
    do_reset(2'b10);
    eoc(1, 1, 16'h0001, 16'h0002);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(comb_req, 1, "R6 request held without ack");
    end
    comb_ack = 1; @(negedge clk); comb_ack = 0;
    chk(comb_req, 0, "R6 request low after transfer");
  endtask

  task automatic t_narrow();
    do_reset(2'b11);
    eoc(1, 1, 16'hA5C3, 16'h7E19);
    chk(comb_word, 32'h001900C3, "R5 narrow zero-extended packing");
    chk({mst_req, slv_req, comb_req}, 3'b001, "R3 single request in narrow mode");
  endtask

  task automatic t_overrun();
    do_reset(2'b00);
    eoc(1, 0, 16'h1111, 16'h0);
    chk(mst_ovr, 0, "R7 no overrun on first result");
    eoc(1, 0, 16'h2222, 16'h0);
    chk({mst_ovr, slv_ovr, mst_dr}, {2'b10, 16'h2222}, "R7 overrun and overwrite");
    mst_ack = 1; @(negedge clk); mst_ack = 0;
    chk(mst_ovr, 1, "R7 overrun sticky after read");
  endtask

  task automatic t_ack_eoc();
    do_reset(2'b00);
    eoc(1, 0, 16'h3333, 16'h0);
    mst_ack = 1;
    eoc(1, 0, 16'h4444, 16'h0);
    mst_ack = 0;
    chk({mst_pend, mst_ovr, mst_req, mst_dr}, {3'b101, 16'h4444}, "R10 refill at read edge");
  endtask

  task automatic t_off();
    do_reset(2'b01);
    eoc(1, 1, 16'h5555, 16'h6666);
    chk({mst_req, slv_req, comb_req}, 0, "R8 no request in mode 01");
    chk(comb_word, 0, "R8 word zero in mode 01");
    chk({mst_pend, slv_pend, mst_dr, slv_dr}, {2'b11, 16'h5555, 16'h6666}, "R8 flags still latch");
  endtask

  initial begin
    t_reset();
    t_separate();
    t_comb_orders();
    t_hold();
    t_narrow();
    t_overrun();
    t_ack_eoc();
    t_off();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule